// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is an 8-bit bidirectional I/O port controller for a small microcontroller core. The CPU reaches a data register and four per-pin configuration registers over a simple register bus. Each register has its own address, writes take one cycle on a strobe, and read data is combinational. For each pin the block drives an output enable and an output value to the pad cell. It also forwards three static pad-control vectors, for pull-up, input threshold and Schmitt trigger, straight from their registers.

Every configuration bit uses an inverted encoding: a zero selects the "active" choice. A zero direction bit drives the pin, a zero pull-up bit turns the pull-up on, and a zero Schmitt bit turns the Schmitt input on. The level bit picks CMOS thresholds with 0 and TTL thresholds with 1. A single read-mode bit chooses what a CPU read of the data address returns: the pin levels after a two-flop synchroniser, or the stored data latch. Writes to the data latch are kept even while a pin is an input, and they reach the pad as soon as that pin is switched to output. The parameter `IMPL_W` builds reduced-pin variants, such as a 4-pin port; its upper positions read as zero and ignore writes.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every implemented direction bit is 1, every pull-up bit is 1, every level bit is 0, every Schmitt bit is 1, the data latch is 0 and the read mode is 0.
- R2: A direction bit of 0 asserts `pin_oe_o` for that pin. A direction bit of 1 deasserts it, which leaves the pin high-impedance.
- R3: A write to the data address always updates the data latch, including bits whose pins are inputs. `pin_out_o` shows the latch at all times, so a retained bit drives its pad once its direction becomes 0.
- R4: `pad_pull_dis_o`, `pad_ttl_o` and `pad_schmitt_dis_o` equal the pull-up, level and Schmitt registers. Pull-up bit 0 means pull-up on, level bit 1 means TTL, and Schmitt bit 0 means Schmitt on.
- R5: With read mode 0, a read of the data address returns the pin levels through a two-flop synchroniser. A change on `pin_i` before clock edge k appears on `rdata_o` after edge k+1, and not after edge k.
- R6: With read mode 1, a read of the data address returns the data latch.
- R7: With read mode 0, an output pin that is forced externally to the opposite level reads back the forced level, not the written value.
- R8: The register addresses are 0 data, 1 direction, 2 pull-up, 3 level, 4 Schmitt and 5 read mode (bit 0). Each configuration register reads back its stored value. Addresses 6 and 7 read 0 and writes to them have no effect.
- R9: With `IMPL_W` below `PORT_W`, the bits at and above `IMPL_W` read 0 at every address, ignore writes, and hold `pin_oe_o`, `pin_out_o` and the pad controls at 0.
- R10: With `wr_en_i` low, no register changes, whatever `addr_i` and `wdata_i` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | PORT_W | Write data |
| rdata_o | output | PORT_W | Combinational read data |
| pin_i | input | PORT_W | Pad input levels (asynchronous) |
| pin_oe_o | output | PORT_W | Per-pin output enable, 1 = drive |
| pin_out_o | output | PORT_W | Per-pin output value (data latch) |
| pad_pull_dis_o | output | PORT_W | Pull-up disable, 0 = pull-up on |
| pad_ttl_o | output | PORT_W | Threshold select, 1 = TTL, 0 = CMOS |
| pad_schmitt_dis_o | output | PORT_W | Schmitt disable, 0 = Schmitt on |

## Verification
The bench writes data while all pins are inputs and then turns half of them into outputs. A design that gated the latch write on direction would drive stale zeros at that point. It forces a driven pin to the opposite level and reads it in both read modes. A design that looped the latch back in pin mode would return the written value, and one with the modes swapped would fail in both reads. The bench samples the read one edge and two edges after a pin change, so a synchroniser with one flop or three flops fails the latency check. A second, 4-pin instance exposes upper bits that leak through from the write data or from the inverted reset values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 3'd0,
    REG_DIR   = 3'd1,
    REG_PULL  = 3'd2,
    REG_LVL   = 3'd3,
    REG_SCHM  = 3'd4,
    REG_RMODE = 3'd5
  } reg_sel_e;

  function automatic logic [63:0] low_mask(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int          W       = 8,
  parameter int          IMPL_W  = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < IMPL_W) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   q_o[i] <= RST_VAL[i];
        else if (we_i) q_o[i] <= wdata_i[i];
      end
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int IMPL_W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_sync_o
);
  localparam logic [W-1:0] MASK = W'(gpio_port_pkg::low_mask(IMPL_W));

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= pin_i & MASK;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign pin_sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_mode_i,
  input  logic [W-1:0]      pin_sync_i,
  input  logic [W-1:0]      data_i,
  input  logic [W-1:0]      dir_i,
  input  logic [W-1:0]      pull_i,
  input  logic [W-1:0]      lvl_i,
  input  logic [W-1:0]      schm_i,
  output logic [W-1:0]      rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_DATA:  rdata_o = rd_mode_i ? data_i : pin_sync_i;
      REG_DIR:   rdata_o = dir_i;
      REG_PULL:  rdata_o = pull_i;
      REG_LVL:   rdata_o = lvl_i;
      REG_SCHM:  rdata_o = schm_i;
      REG_RMODE: rdata_o = W'(rd_mode_i);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IMPL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] pin_out_o,
  output logic [PORT_W-1:0] pad_pull_dis_o,
  output logic [PORT_W-1:0] pad_ttl_o,
  output logic [PORT_W-1:0] pad_schmitt_dis_o
);
  localparam logic [PORT_W-1:0] IMPL_MASK = PORT_W'(low_mask(IMPL_W));
  localparam int                SYNC_STAGES = 2;

  logic [PORT_W-1:0] data_q, dir_q, pull_q, lvl_q, schm_q, pin_sync;
  logic              rd_mode_q;
  logic              we_data, we_dir, we_pull, we_lvl, we_schm, we_rmode;

  assign we_data  = wr_en_i && (addr_i == REG_DATA);
  assign we_dir   = wr_en_i && (addr_i == REG_DIR);
  assign we_pull  = wr_en_i && (addr_i == REG_PULL);
  assign we_lvl   = wr_en_i && (addr_i == REG_LVL);
  assign we_schm  = wr_en_i && (addr_i == REG_SCHM);
  assign we_rmode = wr_en_i && (addr_i == REG_RMODE);

  gpio_cfg_reg #(.W(PORT_W), .IMPL_W(IMPL_W), .RST_VAL('0)) u_data (
    .clk_i, .rst_ni, .we_i(we_data), .wdata_i, .q_o(data_q));

  gpio_cfg_reg #(.W(PORT_W), .IMPL_W(IMPL_W), .RST_VAL(IMPL_MASK)) u_dir (
    .clk_i, .rst_ni, .we_i(we_dir), .wdata_i, .q_o(dir_q));

  gpio_cfg_reg #(.W(PORT_W), .IMPL_W(IMPL_W), .RST_VAL(IMPL_MASK)) u_pull (
    .clk_i, .rst_ni, .we_i(we_pull), .wdata_i, .q_o(pull_q));

  gpio_cfg_reg #(.W(PORT_W), .IMPL_W(IMPL_W), .RST_VAL('0)) u_lvl (
    .clk_i, .rst_ni, .we_i(we_lvl), .wdata_i, .q_o(lvl_q));

  gpio_cfg_reg #(.W(PORT_W), .IMPL_W(IMPL_W), .RST_VAL(IMPL_MASK)) u_schm (
    .clk_i, .rst_ni, .we_i(we_schm), .wdata_i, .q_o(schm_q));

  gpio_cfg_reg #(.W(1), .IMPL_W(1), .RST_VAL(1'b0)) u_rmode (
    .clk_i, .rst_ni, .we_i(we_rmode), .wdata_i(wdata_i[0]), .q_o(rd_mode_q));

  gpio_pin_sync #(.W(PORT_W), .IMPL_W(IMPL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i, .pin_sync_o(pin_sync));

  gpio_read_mux #(.W(PORT_W)) u_rmux (
    .addr_i,
    .rd_mode_i (rd_mode_q),
    .pin_sync_i(pin_sync),
    .data_i    (data_q),
    .dir_i     (dir_q),
    .pull_i    (pull_q),
    .lvl_i     (lvl_q),
    .schm_i    (schm_q),
    .rdata_o
  );

  // unimplemented dir bits are 0 in storage, so mask the inverted enable
  assign pin_oe_o          = ~dir_q & IMPL_MASK;
  assign pin_out_o         = data_q;
  assign pad_pull_dis_o    = pull_q;
  assign pad_ttl_o         = lvl_q;
  assign pad_schmitt_dis_o = schm_q;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int IMPL_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PORT_W-1:0] wdata_i,
  input logic [PORT_W-1:0] rdata_o,
  input logic [PORT_W-1:0] pin_oe_o,
  input logic [PORT_W-1:0] pin_out_o,
  input logic              rd_mode_q
);
  localparam logic [PORT_W-1:0] MASK = PORT_W'(low_mask(IMPL_W));

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DIR) |=> (pin_oe_o == (~$past(wdata_i) & MASK))); // R2

  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_DATA) |=> (pin_out_o == ($past(wdata_i) & MASK))); // R3

  AST_LATCH_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_q && addr_i == REG_DATA) |-> (rdata_o == pin_out_o)); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o | pin_out_o | rdata_o) & ~MASK) == '0); // R9

  AST_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(pin_oe_o) && $stable(pin_out_o))); // R10
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PORT_W(PORT_W), .IMPL_W(IMPL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pin_oe_o  (pin_oe_o),
  .pin_out_o (pin_out_o),
  .rd_mode_q (rd_mode_q)
);

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pin = 8'hA5;
  logic [7:0] rd_w, oe_w, out_w, pull_w, ttl_w, schm_w;
  logic [7:0] rd_n, oe_n, out_n, pull_n, ttl_n, schm_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl #(.PORT_W(8), .IMPL_W(8)) u_dut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_w), .pin_i(pin), .pin_oe_o(oe_w), .pin_out_o(out_w),
    .pad_pull_dis_o(pull_w), .pad_ttl_o(ttl_w), .pad_schmitt_dis_o(schm_w));

  gpio_port_ctrl #(.PORT_W(8), .IMPL_W(4)) u_dut_nar (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_n), .pin_i(pin), .pin_oe_o(oe_n), .pin_out_o(out_n),
    .pad_pull_dis_o(pull_n), .pad_ttl_o(ttl_n), .pad_schmitt_dis_o(schm_n));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_at(input logic [2:0] a);
    addr = a;
    #1;
  endtask

  // {waddr[3], wdata[8], raddr[3], expected[8]} on the wide instance, pins held at A5
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {3'd1, 8'h0F, 3'd1, 8'h0F},  // R8 dir
    {3'd2, 8'h3C, 3'd2, 8'h3C},  // R8 pull
    {3'd3, 8'h81, 3'd3, 8'h81},  // R8 level
    {3'd4, 8'h7E, 3'd4, 8'h7E},  // R8 schmitt
    {3'd0, 8'h5A, 3'd0, 8'hA5},  // R5 pin read
    {3'd5, 8'h01, 3'd0, 8'h5A},  // R6 latch read
    {3'd5, 8'h00, 3'd5, 8'h00},  // R8 mode readback
    {3'd6, 8'hFF, 3'd6, 8'h00}   // R8 unmapped
  };

  initial begin
    #(4_000_000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    addr = 3'd1;
    #25;
    chk("R1 oe", oe_w, 8'h00);
    chk("R1 out", out_w, 8'h00);
    chk("R1 pull", pull_w, 8'hFF);
    chk("R1 ttl", ttl_w, 8'h00);
    chk("R1 schmitt", schm_w, 8'hFF);
    chk("R1 dir read", rd_w, 8'hFF);
    chk("R9 narrow dir reset", rd_n, 8'h0F);
    chk("R9 narrow pull reset", pull_n, 8'h0F);
    addr = 3'd5; #1;
    chk("R1 mode read", rd_w, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr_reg(VEC[i][21:19], VEC[i][18:11]);
      rd_at(VEC[i][10:8]);
      chk($sformatf("table R5/R6/R8 vec %0d", i), rd_w, VEC[i][7:0]);
    end

    // R4 pad controls mirror registers
    chk("R4 pull out", pull_w, 8'h3C);
    chk("R4 ttl out", ttl_w, 8'h81);
    chk("R4 schmitt out", schm_w, 8'h7E);

    // R3 retained write while input, then R2 switch to output
    wr_reg(3'd1, 8'hFF);
    chk("R2 all inputs", oe_w, 8'h00);
    wr_reg(3'd0, 8'hC3);
    chk("R3 latch while input", out_w, 8'hC3);
    chk("R3 no drive while input", oe_w, 8'h00);
    wr_reg(3'd1, 8'hF0);
    chk("R2 low nibble output", oe_w, 8'h0F);
    chk("R3 retained drives", out_w & oe_w, 8'h03);

    // R7 forced pin, R5 latency
    pin = 8'h0C;
    @(posedge clk); @(negedge clk);
    rd_at(3'd0);
    chk("R5 one edge still old", rd_w, 8'hA5);
    @(negedge clk); #1;
    chk("R7 forced level read", rd_w, 8'h0C);
    wr_reg(3'd5, 8'h01);
    rd_at(3'd0);
    chk("R6 latch despite force", rd_w, 8'hC3);

    // R10 no strobe
    @(negedge clk);
    addr = 3'd1; wdata = 8'h00; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rd_at(3'd1);
    chk("R10 dir held", rd_w, 8'hF0);
    chk("R10 oe held", oe_w, 8'h0F);

    // R9 narrow instance
    wr_reg(3'd1, 8'h00);
    chk("R9 narrow oe", oe_n, 8'h0F);
    chk("R9 wide oe", oe_w, 8'hFF);
    rd_at(3'd1);
    chk("R9 narrow dir read", rd_n, 8'h00);
    wr_reg(3'd0, 8'hFF);
    chk("R9 narrow out", out_n, 8'h0F);
    rd_at(3'd0);
    chk("R9 narrow latch read", rd_n, 8'h0F);
    wr_reg(3'd2, 8'hF0);
    chk("R9 narrow pull upper", pull_n, 8'h00);
    wr_reg(3'd5, 8'h00);
    pin = 8'hFF;
    repeat (3) @(negedge clk);
    rd_at(3'd0);
    chk("R9 narrow pin read", rd_n, 8'h0F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule